// File: doc/BRIEF.md
# Scalar Memory Instruction Decoder

This block takes one 64-bit scalar-memory instruction word at a time and turns it into a burst of single-dword requests toward a memory or cache port. When a word is presented, the block reads the register pair that holds the base address, and the register named by the offset field if there is one, through a combinational register-file read port. It then checks the encoding tag and the opcode, forms a byte address, and issues one request per dword on a valid/ready interface. Each request carries a command code, an address, the scalar register index for that dword, a store flag, the coherence bit and a last-of-burst marker.

Plain loads and stores take their base from a register pair. Buffer loads and stores take it from a four-register descriptor whose first pair holds the address. Line-discard opcodes produce line-aligned addresses. Cache-invalidate and timer-read opcodes each produce a single control request with a zero address. Words that fail the encoding, opcode or operand rules raise a one-cycle illegal pulse, and the block issues no request for them.

Top module: `smem_decoder`

## Requirements
- R1: An instruction whose encoding tag (bits 31:26) differs from 6'b110000 is accepted, `illegal` is high for the cycle after acceptance, and no request is issued.
- R2: The address of the first request is the 48-bit base (`rf_base_hi[15:0]` over `rf_base_lo`) plus the byte offset with its two low bits forced to zero. When bit 17 is 1, the offset is the 20-bit field in bits 51:32. When bit 17 is 0, the offset is `rf_off_val`, read from the register named by bits 38:32.
- R3: Opcodes 0 to 4 (bits 25:18) issue 1, 2, 4, 8 or 16 read requests (`req_cmd`=0, `req_store`=0) at addresses 4 bytes apart. Request i carries `req_dst` = bits 12:6 plus i, and `req_glc` equal to bit 16.
- R4: Opcodes 8 to 12 are buffer reads of 1, 2, 4, 8 or 16 dwords. An odd base index (bits 5:0) makes them illegal.
- R5: Opcodes 16 to 18 and 24 to 26 issue 1, 2 or 4 write requests (`req_cmd`=1, `req_store`=1), with the same odd-base rule for 24 to 26. A register-sourced offset that names any register other than index 124 is illegal.
- R6: Opcodes 40 and 41 form their address the way a store does, clear its six low bits, and issue 1 or 2 requests (`req_cmd`=6) at addresses 64 bytes apart.
- R7: Opcodes 32, 34, 36 and 37 issue a single last request with address 0 and `req_cmd` 2, 3, 4 and 5 respectively.
- R8: Any opcode not listed above raises `illegal` for exactly one cycle and issues nothing.
- R9: A request that is not accepted stays unchanged. `instr_ready` is low from acceptance until the last request is taken, and an instruction offered during that time is ignored.
- R10: `rf_base_idx` equals twice bits 5:0 of the presented word.
- R11: After reset, `req_valid` and `illegal` are low and `instr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 64 | Instruction word |
| instr_ready | output | 1 | Block idle, word taken at this edge |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| rf_base_idx | output | 7 | Register index of base low half |
| rf_base_lo | input | 32 | Value of register `rf_base_idx` |
| rf_base_hi | input | 32 | Value of register `rf_base_idx`+1 |
| rf_off_idx | output | 7 | Register index holding the offset |
| rf_off_val | input | 32 | Value of register `rf_off_idx` |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request taken at this edge |
| req_cmd | output | 3 | Command code |
| req_addr | output | 48 | Byte address |
| req_dst | output | 7 | Scalar register of this dword |
| req_store | output | 1 | Write request |
| req_glc | output | 1 | Coherence bit of the instruction |
| req_last | output | 1 | Final request of the burst |

## Verification
The first request, or the illegal pulse, appears in the cycle that follows the rising edge at which the word is taken. Each later request follows the rising edge at which the previous one was accepted. The bench changes inputs on the falling edge and reads outputs at the next falling edge after each rising edge, so every comparison lands on the cycle in which its result is due. The illegal pulse is checked in that cycle and again one cycle later, to confirm that it has ended and that no request appeared.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int RIDX_W = 7;
    localparam int LEN_W  = 5;
    localparam logic [5:0] ENC_TAG = 6'b110000;

    typedef enum logic [2:0] {
        CMD_READ    = 3'd0,
        CMD_WRITE   = 3'd1,
        CMD_INV_ALL = 3'd2,
        CMD_INV_VOL = 3'd3,
        CMD_TIMER   = 3'd4,
        CMD_RTC     = 3'd5,
        CMD_DISCARD = 3'd6
    } smem_cmd_e;

    typedef struct packed {
        logic             legal;
        smem_cmd_e        cmd;
        logic [LEN_W-1:0] len;
        logic             uses_addr;
        logic             line_align;
    } smem_dec_t;

endpackage

// File: rtl/smem_op_decode.sv
module smem_op_decode
    import smem_pkg::*;
#(
    parameter int M0_IDX = 124
) (
    input  logic [7:0]        opcode,
    input  logic              sbase_lsb,
    input  logic              imm,
    input  logic [RIDX_W-1:0] off_idx,
    output smem_dec_t         dec
);

    logic known;
    logic buffer_op;
    logic store_rule;

    always_comb begin
        dec        = '0;
        dec.cmd    = CMD_READ;
        dec.len    = LEN_W'(1);
        known      = 1'b0;
        buffer_op  = 1'b0;
        store_rule = 1'b0;
        if (opcode[7:3] == 5'd0 && opcode[2:0] <= 3'd4) begin
            known         = 1'b1;
            dec.len       = LEN_W'(1) << opcode[2:0];
            dec.uses_addr = 1'b1;
        end else if (opcode[7:3] == 5'd1 && opcode[2:0] <= 3'd4) begin
            known         = 1'b1;
            buffer_op     = 1'b1;
            dec.len       = LEN_W'(1) << opcode[2:0];
            dec.uses_addr = 1'b1;
        end else if ((opcode[7:3] == 5'd2 || opcode[7:3] == 5'd3) && opcode[2:0] <= 3'd2) begin
            known         = 1'b1;
            buffer_op     = opcode[3];
            store_rule    = 1'b1;
            dec.cmd       = CMD_WRITE;
            dec.len       = LEN_W'(1) << opcode[2:0];
            dec.uses_addr = 1'b1;
        end else begin
            case (opcode)
                8'd32: begin known = 1'b1; dec.cmd = CMD_INV_ALL; end
                8'd34: begin known = 1'b1; dec.cmd = CMD_INV_VOL; end
                8'd36: begin known = 1'b1; dec.cmd = CMD_TIMER;   end
                8'd37: begin known = 1'b1; dec.cmd = CMD_RTC;     end
                8'd40, 8'd41: begin
                    known          = 1'b1;
                    store_rule     = 1'b1;
                    dec.cmd        = CMD_DISCARD;
                    dec.len        = opcode[0] ? LEN_W'(2) : LEN_W'(1);
                    dec.uses_addr  = 1'b1;
                    dec.line_align = 1'b1;
                end
                default: known = 1'b0;
            endcase
        end
        dec.legal = known
                  && !(buffer_op && sbase_lsb)
                  && !(store_rule && !imm && off_idx != RIDX_W'(M0_IDX));
    end

endmodule

// File: rtl/smem_addr_gen.sv
module smem_addr_gen #(
    parameter int ADDR_W     = 48,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 20,
    parameter int LINE_BYTES = 64
) (
    input  logic [DATA_W-1:0] base_lo,
    input  logic [DATA_W-1:0] base_hi,
    input  logic              imm,
    input  logic [OFF_W-1:0]  off_field,
    input  logic [DATA_W-1:0] off_reg_val,
    input  logic              line_align,
    output logic [ADDR_W-1:0] addr
);

    localparam int FULL_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    logic [FULL_W-1:0] base_full;
    logic [DATA_W-1:0] off_sel;
    logic [DATA_W-1:0] off_word;
    logic [ADDR_W-1:0] sum;
    logic              unused_base_top;

    assign base_full       = {base_hi, base_lo};
    assign unused_base_top = ^base_full[FULL_W-1:ADDR_W];

    always_comb begin
        off_sel  = imm ? DATA_W'(off_field) : off_reg_val;
        off_word = off_sel & ~DATA_W'(3);
        sum      = base_full[ADDR_W-1:0] + ADDR_W'(off_word);
        addr     = line_align ? (sum & LINE_MASK) : sum;
    end

endmodule

// File: rtl/smem_decoder.sv
module smem_decoder
    import smem_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int DATA_W     = 32,
    parameter int M0_IDX     = 124,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [63:0]       instr_word,
    output logic              instr_ready,
    output logic              illegal,
    output logic [6:0]        rf_base_idx,
    input  logic [31:0]       rf_base_lo,
    input  logic [31:0]       rf_base_hi,
    output logic [6:0]        rf_off_idx,
    input  logic [31:0]       rf_off_val,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_cmd,
    output logic [47:0]       req_addr,
    output logic [6:0]        req_dst,
    output logic              req_store,
    output logic              req_glc,
    output logic              req_last
);

    localparam int OFF_W = 20;
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_LINE = ADDR_W'(LINE_BYTES);

    typedef struct packed {
        logic              busy;
        logic              illegal;
        smem_cmd_e         cmd;
        logic              glc;
        logic [ADDR_W-1:0] addr;
        logic [RIDX_W-1:0] dst;
        logic [LEN_W-1:0]  rem;
    } state_t;

    state_t st_d, st_q;

    // instruction fields
    logic [5:0]        f_sbase;
    logic [RIDX_W-1:0] f_sdata;
    logic              f_glc;
    logic              f_imm;
    logic [7:0]        f_op;
    logic [5:0]        f_enc;
    logic [OFF_W-1:0]  f_off;
    logic              unused_fields;

    assign f_sbase = instr_word[5:0];
    assign f_sdata = instr_word[12:6];
    assign f_glc   = instr_word[16];
    assign f_imm   = instr_word[17];
    assign f_op    = instr_word[25:18];
    assign f_enc   = instr_word[31:26];
    assign f_off   = instr_word[51:32];
    assign unused_fields = ^{instr_word[15:13], instr_word[63:52]};

    assign rf_base_idx = {f_sbase, 1'b0};
    assign rf_off_idx  = f_off[RIDX_W-1:0];

    smem_dec_t         dec;
    logic [ADDR_W-1:0] ea;

    smem_op_decode #(.M0_IDX(M0_IDX)) u_op_decode (
        .opcode    (f_op),
        .sbase_lsb (f_sbase[0]),
        .imm       (f_imm),
        .off_idx   (f_off[RIDX_W-1:0]),
        .dec       (dec)
    );

    smem_addr_gen #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .OFF_W      (OFF_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_addr_gen (
        .base_lo     (rf_base_lo),
        .base_hi     (rf_base_hi),
        .imm         (f_imm),
        .off_field   (f_off),
        .off_reg_val (rf_off_val),
        .line_align  (dec.line_align),
        .addr        (ea)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        if (!st_q.busy) begin
            if (instr_valid) begin
                if (dec.legal && f_enc == ENC_TAG) begin
                    st_d.busy = 1'b1;
                    st_d.cmd  = dec.cmd;
                    st_d.glc  = f_glc;
                    st_d.addr = dec.uses_addr ? ea : '0;
                    st_d.dst  = f_sdata;
                    st_d.rem  = dec.len;
                end else begin
                    st_d.illegal = 1'b1;
                end
            end
        end else if (req_ready) begin
            st_d.rem  = st_q.rem - LEN_W'(1);
            st_d.dst  = st_q.dst + RIDX_W'(1);
            st_d.addr = st_q.addr + ((st_q.cmd == CMD_DISCARD) ? STEP_LINE : STEP_WORD);
            if (st_q.rem == LEN_W'(1)) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr_ready = !st_q.busy;
    assign illegal     = st_q.illegal;
    assign req_valid   = st_q.busy;
    assign req_cmd     = st_q.cmd;
    assign req_addr    = st_q.addr;
    assign req_dst     = st_q.dst;
    assign req_store   = st_q.cmd == CMD_WRITE;
    assign req_glc     = st_q.glc;
    assign req_last    = st_q.busy && st_q.rem == LEN_W'(1);

endmodule

// File: rtl/smem_decoder_chk.sv
module smem_decoder_chk
    import smem_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              illegal,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_cmd,
    input logic [ADDR_W-1:0] req_addr,
    input logic [6:0]        req_dst,
    input logic              req_last
);

    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_LINE = ADDR_W'(LINE_BYTES);

    // R1 / R8: a rejected word never produces a request
    p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !req_valid);

    // R9: a stalled request holds every field
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_cmd) && $stable(req_dst));

    // R9: burst ends after its last request is taken
    p_end_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_last |=> !req_valid);

    // R3: consecutive requests step address and register index
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_last |=> req_valid
            && req_addr == $past(req_addr)
               + (($past(req_cmd) == 3'(CMD_DISCARD)) ? STEP_LINE : STEP_WORD)
            && req_dst == $past(req_dst) + 7'd1);

    // R6: discard addresses sit on a line boundary
    p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_cmd == 3'(CMD_DISCARD) |-> req_addr[5:0] == 6'd0);

    // R7: control requests carry no address and stand alone
    p_ctrl_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_cmd >= 3'(CMD_INV_ALL) && req_cmd <= 3'(CMD_RTC)
            |-> req_addr == '0 && req_last);

endmodule

bind smem_decoder smem_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .illegal   (illegal),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .req_dst   (req_dst),
    .req_last  (req_last)
);

// File: tb/smem_decoder_bench.sv
`timescale 1ns/1ps
module smem_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [63:0] instr_word = '0;
    logic        instr_ready;
    logic        illegal;
    logic [6:0]  rf_base_idx;
    logic [31:0] rf_base_lo;
    logic [31:0] rf_base_hi;
    logic [6:0]  rf_off_idx;
    logic [31:0] rf_off_val;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [2:0]  req_cmd;
    logic [47:0] req_addr;
    logic [6:0]  req_dst;
    logic        req_store;
    logic        req_glc;
    logic        req_last;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    smem_decoder u_smem_decoder (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_word(instr_word), .instr_ready(instr_ready),
        .illegal(illegal),
        .rf_base_idx(rf_base_idx), .rf_base_lo(rf_base_lo), .rf_base_hi(rf_base_hi),
        .rf_off_idx(rf_off_idx), .rf_off_val(rf_off_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_dst(req_dst), .req_store(req_store),
        .req_glc(req_glc), .req_last(req_last)
    );

    // register file model: register k holds k*4096, plus 3 when k is odd
    function automatic logic [31:0] rfv(input logic [6:0] k);
        return ({25'd0, k} << 12) | (k[0] ? 32'd3 : 32'd0);
    endfunction

    assign rf_base_lo = rfv(rf_base_idx);
    assign rf_base_hi = rfv(rf_base_idx + 7'd1);
    assign rf_off_val = rfv(rf_off_idx);

    typedef struct packed {
        logic [5:0]  enc;
        logic [7:0]  op;
        logic [5:0]  sbase;
        logic [6:0]  sdata;
        logic        imm;
        logic        glc;
        logic [19:0] off;
        logic        ill;
        logic [2:0]  cmd;
        logic [4:0]  len;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{6'h30, 8'd0,  6'd1, 7'd10, 1'b1, 1'b0, 20'h00013, 1'b0, 3'd0, 5'd1},
        '{6'h30, 8'd2,  6'd2, 7'd20, 1'b0, 1'b1, 20'd5,     1'b0, 3'd0, 5'd4},
        '{6'h30, 8'd4,  6'd3, 7'd40, 1'b1, 1'b0, 20'hFFFFF, 1'b0, 3'd0, 5'd16},
        '{6'h30, 8'd11, 6'd2, 7'd60, 1'b1, 1'b0, 20'h00104, 1'b0, 3'd0, 5'd8},
        '{6'h30, 8'd9,  6'd3, 7'd1,  1'b1, 1'b0, 20'h00000, 1'b1, 3'd0, 5'd0},
        '{6'h30, 8'd17, 6'd1, 7'd12, 1'b0, 1'b0, 20'd124,   1'b0, 3'd1, 5'd2},
        '{6'h30, 8'd16, 6'd1, 7'd12, 1'b0, 1'b0, 20'd5,     1'b1, 3'd0, 5'd0},
        '{6'h30, 8'd26, 6'd4, 7'd30, 1'b1, 1'b1, 20'h00040, 1'b0, 3'd1, 5'd4},
        '{6'h30, 8'd40, 6'd1, 7'd0,  1'b1, 1'b0, 20'h0007F, 1'b0, 3'd6, 5'd1},
        '{6'h30, 8'd41, 6'd2, 7'd0,  1'b0, 1'b0, 20'd124,   1'b0, 3'd6, 5'd2},
        '{6'h30, 8'd32, 6'd0, 7'd3,  1'b1, 1'b0, 20'h00000, 1'b0, 3'd2, 5'd1},
        '{6'h30, 8'd34, 6'd0, 7'd3,  1'b1, 1'b0, 20'h00000, 1'b0, 3'd3, 5'd1},
        '{6'h30, 8'd36, 6'd0, 7'd8,  1'b1, 1'b0, 20'h00000, 1'b0, 3'd4, 5'd1},
        '{6'h30, 8'd37, 6'd0, 7'd8,  1'b1, 1'b1, 20'h00000, 1'b0, 3'd5, 5'd1},
        '{6'h30, 8'd33, 6'd0, 7'd8,  1'b1, 1'b0, 20'h00000, 1'b1, 3'd0, 5'd0},
        '{6'h30, 8'd5,  6'd1, 7'd8,  1'b1, 1'b0, 20'h00000, 1'b1, 3'd0, 5'd0},
        '{6'h31, 8'd0,  6'd1, 7'd8,  1'b1, 1'b0, 20'h00000, 1'b1, 3'd0, 5'd0},
        '{6'h30, 8'd25, 6'd2, 7'd8,  1'b0, 1'b0, 20'd7,     1'b1, 3'd0, 5'd0},
        '{6'h30, 8'd8,  6'd4, 7'd50, 1'b0, 1'b0, 20'd7,     1'b0, 3'd0, 5'd1},
        '{6'h30, 8'd40, 6'd1, 7'd0,  1'b0, 1'b0, 20'd5,     1'b1, 3'd0, 5'd0}
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input vec_t v);
        logic [63:0] w;
        w        = '0;
        w[5:0]   = v.sbase;
        w[12:6]  = v.sdata;
        w[15:13] = 3'b101;
        w[16]    = v.glc;
        w[17]    = v.imm;
        w[25:18] = v.op;
        w[31:26] = v.enc;
        w[51:32] = v.off;
        w[63:52] = 12'hABC;
        return w;
    endfunction

    function automatic logic [47:0] exp_addr(input vec_t v);
        logic [47:0] base;
        logic [31:0] o;
        logic [47:0] a;
        logic [31:0] hi;
        hi   = rfv({v.sbase, 1'b0} + 7'd1);
        base = {hi[15:0], rfv({v.sbase, 1'b0})};
        o    = v.imm ? {12'd0, v.off} : rfv(v.off[6:0]);
        o[1:0] = 2'b00;
        a    = base + {16'd0, o};
        if (v.op == 8'd40 || v.op == 8'd41) a[5:0] = 6'd0;
        if (v.op >= 8'd32 && v.op <= 8'd37) a = '0;
        return a;
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.enc != 6'h30) return "R1";
        if (v.op <= 8'd4) return "R3";
        if (v.op >= 8'd8 && v.op <= 8'd12) return "R4";
        if ((v.op >= 8'd16 && v.op <= 8'd18) || (v.op >= 8'd24 && v.op <= 8'd26)) return "R5";
        if (v.op == 8'd40 || v.op == 8'd41) return "R6";
        if (v.op == 8'd32 || v.op == 8'd34 || v.op == 8'd36 || v.op == 8'd37) return "R7";
        return "R8";
    endfunction

    task automatic run_vec(input vec_t v);
        string       tag;
        logic [47:0] a0;
        logic [47:0] stride;
        tag    = tag_of(v);
        a0     = exp_addr(v);
        stride = (v.cmd == 3'd6) ? 48'd64 : 48'd4;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk(v);
        req_ready   = 1'b1;
        #1;
        chk(rf_base_idx == {v.sbase, 1'b0}, "R10", "base index",
            64'(rf_base_idx), 64'({v.sbase, 1'b0}));
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        if (v.ill) begin
            chk(illegal === 1'b1 && req_valid === 1'b0, tag, "illegal pulse",
                {62'd0, illegal, req_valid}, 64'd2);
            @(negedge clk);
            chk(illegal === 1'b0 && req_valid === 1'b0 && instr_ready === 1'b1, "R8",
                "pulse ends, nothing issued", {61'd0, illegal, req_valid, instr_ready}, 64'd1);
        end else begin
            for (int i = 0; i < int'(v.len); i++) begin
                logic [63:0] act, exp;
                act = {50'd0, req_valid, req_cmd, req_dst, req_store, req_glc, req_last};
                exp = {50'd0, 1'b1, v.cmd, 7'(v.sdata + 7'(i)), v.cmd == 3'd1, v.glc,
                       i == int'(v.len) - 1};
                chk(act === exp, tag, "request fields", act, exp);
                chk(req_addr === a0 + stride * 48'(i), "R2", "request address",
                    64'(req_addr), 64'(a0 + stride * 48'(i)));
                @(posedge clk);
                @(negedge clk);
            end
            chk(req_valid === 1'b0 && instr_ready === 1'b1, "R9", "idle after burst",
                {62'd0, req_valid, instr_ready}, 64'd1);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        vec_t        sv;
        logic [47:0] sa;
        repeat (3) @(negedge clk);
        chk(req_valid === 1'b0 && illegal === 1'b0 && instr_ready === 1'b1, "R11",
            "reset state", {61'd0, req_valid, illegal, instr_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k]);
        end

        // stall with a competing instruction offered while busy (R9)
        sv = '{6'h30, 8'd1, 6'd1, 7'd22, 1'b1, 1'b0, 20'h00008, 1'b0, 3'd0, 5'd2};
        sa = exp_addr(sv);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk(sv);
        @(posedge clk);
        @(negedge clk);
        instr_word = mk('{6'h30, 8'd32, 6'd0, 7'd0, 1'b1, 1'b0, 20'd0, 1'b0, 3'd2, 5'd1});
        req_ready  = 1'b0;
        for (int s = 0; s < 4; s++) begin
            chk(req_valid === 1'b1 && req_addr === sa && req_dst === 7'd22
                && req_last === 1'b0 && instr_ready === 1'b0, "R9", "held while stalled",
                {14'd0, req_addr, req_valid, req_last}, {14'd0, sa, 2'b10});
            @(negedge clk);
        end
        instr_valid = 1'b0;
        req_ready   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_valid === 1'b1 && req_addr === sa + 48'd4 && req_last === 1'b1, "R9",
            "second dword after stall", {14'd0, req_addr, req_valid, req_last},
            {14'd0, sa + 48'd4, 2'b11});
        @(posedge clk);
        @(negedge clk);
        chk(req_valid === 1'b0 && illegal === 1'b0 && instr_ready === 1'b1, "R9",
            "offered word ignored", {61'd0, req_valid, illegal, instr_ready}, 64'd1);

        // reset during a burst (R11)
        sv = '{6'h30, 8'd4, 6'd1, 7'd0, 1'b1, 1'b0, 20'h00000, 1'b0, 3'd0, 5'd16};
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk(sv);
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req_valid === 1'b0 && illegal === 1'b0 && instr_ready === 1'b1, "R11",
            "reset mid burst", {61'd0, req_valid, illegal, instr_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule